// File: doc/BRIEF.md
# Averaging Time-to-Digital Converter Back End

This block is the digital back end of a delay-line time-to-digital converter that gains resolution by averaging. Several delay chains run in parallel, and each one hands the back end an encoded fine code on every clock. When a hit is flagged, the back end keeps the chain codes from the hit cycle and from the following clock cycles, so it holds several samples per chain. It shifts every sample onto the same time reference by adding one clock period, expressed in bins, for each edge that sample lags the hit cycle. It then adds all the corrected readings in a pipelined adder tree and reports the full-precision sum with the coarse count it latched in the hit cycle. Dividing the sum by the number of readings gives a fine time finer than one bin; that division is left to the consumer.

Two parameters set the shape of the block: the chain count and the samples per chain. More samples per chain lengthen the dead time by one cycle each but need no extra accumulators. More chains add accumulators and adder-tree nodes, and their cost in dead time is only the logarithmic depth of the tree. A small controller tracks the measurement. In `ST_IDLE` it waits for a hit. The hit moves it to `ST_COLLECT`, where it gathers the remaining samples. Once the last sample is in, it moves to `ST_REDUCE`, where it waits out the tree latency. It then spends one cycle in `ST_EMIT`, which raises the valid pulse, and returns to `ST_IDLE`. When there is one sample per chain the controller skips `ST_COLLECT`. When there is one chain it skips `ST_REDUCE`. Busy is high in every state except `ST_IDLE`, and a hit that arrives while busy is high is dropped.

Top module: `avg_tdc_backend`

## Requirements
- R1: After reset, `busy_o` and `valid_o` are both low.
- R2: A hit in a cycle where `busy_o` is low is accepted: `busy_o` is high from the next cycle on, and `coarse_i` from the hit cycle is captured.
- R3: The hit cycle is sample k = 0. Sample k of a chain comes from the k-th cycle after the hit cycle, for k = 0 to `NUM_SAMPLES`-1. `CLK_BINS`·k is added to sample k before summation, so with all codes zero the sum is `NUM_CHAINS`·`CLK_BINS`·N(N-1)/2.
- R4: `sum_o` equals the sum, over all chains and samples, of (code + `CLK_BINS`·k), at full precision and not truncated. Chain c's code is `fine_i[c*CODE_W +: CODE_W]`.
- R5: `valid_o` is a one-cycle pulse in cycle `NUM_SAMPLES` + log2(`NUM_CHAINS`), counting the hit cycle as cycle 0.
- R6: `busy_o` stays high from the cycle after the hit through the `valid_o` cycle, and it is low in the cycle that follows.
- R7: A hit while `busy_o` is high has no effect: the sum, the coarse value and the pulse timing are those of the accepted hit, and no extra pulse follows.
- R8: A hit in the cycle directly after the `valid_o` cycle is accepted, so measurements can run back to back.
- R9: `coarse_o` is stable from the cycle after the hit through the `valid_o` cycle, where it shows the captured value.
- R10: With every code at its maximum (2^`CODE_W`-1) the sum is exact and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers use its rising edge |
| rst_n | input | 1 | Active-low reset |
| hit_i | input | 1 | A hit is present in this cycle; these codes are sample 0 |
| fine_i | input | NUM_CHAINS*CODE_W | Encoded fine code of every chain; chain c at bits c*CODE_W and up |
| coarse_i | input | COARSE_W | Running coarse clock count |
| busy_o | output | 1 | A measurement is in progress and further hits are dropped |
| valid_o | output | 1 | One-cycle pulse: `sum_o` and `coarse_o` hold a result |
| sum_o | output | SUM_W | Full-precision sum of all corrected samples |
| coarse_o | output | COARSE_W | Coarse count captured in the hit cycle |

## Verification
The result pulse of one measurement and the acceptance of the next hit fall in neighbouring cycles. A hit may also arrive in the very cycle of the pulse. The bench drives a hit on the pulse cycle and checks that busy has dropped one cycle later; a wrongly accepted hit would keep busy high. It then drives a real hit in that very cycle and checks that the new sum and coarse value belong to that hit alone. Other sweeps place dropped hits at the first busy cycle and at every busy cycle, and they fill the chain inputs with unrelated codes outside the sampling window. A sample taken one cycle too early or too late therefore changes the sum.

// File: rtl/tdc_avg_pkg.sv
package tdc_avg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_REDUCE  = 2'd2,
        ST_EMIT    = 2'd3
    } seq_state_e;

endpackage

// File: rtl/tdc_seq_fsm.sv
module tdc_seq_fsm
    import tdc_avg_pkg::*;
#(
    parameter int NUM_SAMPLES = 4,
    parameter int LEVELS      = 3,
    parameter int CLK_BINS    = 400,
    parameter int ACC_W       = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_i,
    output logic             load_first_o,
    output logic             add_more_o,
    output logic [ACC_W-1:0] offset_o,
    output logic             busy_o,
    output logic             emit_o
);
    localparam int KW = $clog2(NUM_SAMPLES + 1);
    localparam int RW = (LEVELS > 1) ? $clog2(LEVELS) : 1;
    localparam seq_state_e AFTER_SAMPLES = (LEVELS == 0) ? ST_EMIT : ST_REDUCE;

    seq_state_e       state_q, state_d;
    logic [KW-1:0]    samp_q;
    logic [RW-1:0]    red_q;
    logic [ACC_W-1:0] off_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (hit_i) state_d = (NUM_SAMPLES == 1) ? AFTER_SAMPLES : ST_COLLECT;
            end
            ST_COLLECT: begin
                if (samp_q == KW'(NUM_SAMPLES - 1)) state_d = AFTER_SAMPLES;
            end
            ST_REDUCE: begin
                if (red_q == RW'(LEVELS - 1)) state_d = ST_EMIT;
            end
            ST_EMIT: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // sample index, time offset and tree wait counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_q <= '0;
            off_q  <= '0;
            red_q  <= '0;
        end else begin
            if (state_q == ST_IDLE && hit_i) begin
                samp_q <= KW'(1);
                off_q  <= ACC_W'(CLK_BINS);
            end else if (state_q == ST_COLLECT) begin
                samp_q <= samp_q + 1'b1;
                off_q  <= off_q + ACC_W'(CLK_BINS);
            end
            if (state_q == ST_REDUCE) red_q <= red_q + 1'b1;
            else                      red_q <= '0;
        end
    end

    // outputs
    always_comb begin
        load_first_o = (state_q == ST_IDLE) && hit_i;
        add_more_o   = (state_q == ST_COLLECT);
        offset_o     = off_q;
        busy_o       = (state_q != ST_IDLE);
        emit_o       = (state_q == ST_EMIT);
    end

    // R2
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(hit_i));

    // R5
    emit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        emit_o |=> !emit_o);

endmodule

// File: rtl/chain_accum.sv
module chain_accum #(
    parameter int CODE_W = 9,
    parameter int ACC_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_first,
    input  logic              add_more,
    input  logic [CODE_W-1:0] code_i,
    input  logic [ACC_W-1:0]  offset_i,
    output logic [ACC_W-1:0]  acc_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          acc_o <= '0;
        else if (load_first) acc_o <= ACC_W'(code_i);
        else if (add_more)   acc_o <= acc_o + ACC_W'(code_i) + offset_i;
    end
endmodule

// File: rtl/pair_add_stage.sv
module pair_add_stage #(
    parameter int W    = 16,
    parameter int IN_N = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [IN_N*W-1:0]       d,
    output logic [(IN_N/2)*W-1:0]   q
);
    localparam int OUT_N = IN_N / 2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            for (int i = 0; i < OUT_N; i++) begin
                q[i*W +: W] <= d[(2*i)*W +: W] + d[(2*i+1)*W +: W];
            end
        end
    end
endmodule

// File: rtl/avg_tdc_backend.sv
module avg_tdc_backend #(
    parameter int NUM_CHAINS  = 8,
    parameter int NUM_SAMPLES = 4,
    parameter int CODE_W      = 9,
    parameter int CLK_BINS    = 400,
    parameter int COARSE_W    = 24,
    localparam int SAMP_MAX   = (1 << CODE_W) - 1 + (NUM_SAMPLES - 1) * CLK_BINS,
    localparam int SUM_W      = $clog2(NUM_CHAINS * NUM_SAMPLES * SAMP_MAX + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         hit_i,
    input  logic [NUM_CHAINS*CODE_W-1:0] fine_i,
    input  logic [COARSE_W-1:0]          coarse_i,
    output logic                         busy_o,
    output logic                         valid_o,
    output logic [SUM_W-1:0]             sum_o,
    output logic [COARSE_W-1:0]          coarse_o
);
    localparam int ACC_W  = $clog2(NUM_SAMPLES * SAMP_MAX + 1);
    localparam int LEVELS = $clog2(NUM_CHAINS);
    localparam int LEAVES = 1 << LEVELS;
    localparam int DW     = $clog2(NUM_SAMPLES + LEVELS + 1);

    logic                         load_first, add_more, emit;
    logic [ACC_W-1:0]             offset;
    logic [NUM_CHAINS*ACC_W-1:0]  acc_flat;
    logic [COARSE_W-1:0]          coarse_q;
    wire  [LEVELS:0][LEAVES*SUM_W-1:0] tree_bus;

    tdc_seq_fsm #(
        .NUM_SAMPLES (NUM_SAMPLES),
        .LEVELS      (LEVELS),
        .CLK_BINS    (CLK_BINS),
        .ACC_W       (ACC_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .hit_i        (hit_i),
        .load_first_o (load_first),
        .add_more_o   (add_more),
        .offset_o     (offset),
        .busy_o       (busy_o),
        .emit_o       (emit)
    );

    for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
        chain_accum #(
            .CODE_W (CODE_W),
            .ACC_W  (ACC_W)
        ) u_acc (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_first (load_first),
            .add_more   (add_more),
            .code_i     (fine_i[c*CODE_W +: CODE_W]),
            .offset_i   (offset),
            .acc_o      (acc_flat[c*ACC_W +: ACC_W])
        );
    end

    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        if (i < NUM_CHAINS) begin : g_used
            assign tree_bus[0][i*SUM_W +: SUM_W] = SUM_W'(acc_flat[i*ACC_W +: ACC_W]);
        end else begin : g_pad
            assign tree_bus[0][i*SUM_W +: SUM_W] = '0;
        end
    end

    for (genvar l = 0; l < LEVELS; l++) begin : g_level
        pair_add_stage #(
            .W    (SUM_W),
            .IN_N (LEAVES >> l)
        ) u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (tree_bus[l][(LEAVES >> l)*SUM_W-1:0]),
            .q     (tree_bus[l+1][(LEAVES >> (l+1))*SUM_W-1:0])
        );
        assign tree_bus[l+1][LEAVES*SUM_W-1:(LEAVES >> (l+1))*SUM_W] = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          coarse_q <= '0;
        else if (load_first) coarse_q <= coarse_i;
    end

    always_comb begin
        valid_o  = emit;
        sum_o    = tree_bus[LEVELS][SUM_W-1:0];
        coarse_o = coarse_q;
    end

    // busy-cycle counter for the dead-time check
    logic [DW-1:0] dwell_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       dwell_cnt <= '0;
        else if (!busy_o) dwell_cnt <= '0;
        else              dwell_cnt <= dwell_cnt + 1'b1;
    end

    // R5
    valid_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (busy_o && dwell_cnt == DW'(NUM_SAMPLES - 1 + LEVELS)));

    // R6
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !busy_o);

    // R9
    coarse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(coarse_o));

endmodule

// File: tb/avg_tdc_backend_bench.sv
module avg_tdc_backend_bench;
    localparam int CLK_P  = 10;
    localparam int M      = 4;
    localparam int N      = 3;
    localparam int P      = 100;
    localparam int CW     = 9;
    localparam int CRW    = 16;
    localparam int LEVELS = 2;
    localparam int LAT    = N + LEVELS;
    localparam int SW     = $clog2(M * N * ((1 << CW) - 1 + (N - 1) * P) + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            hit = 1'b0;
    logic [M*CW-1:0] fine = '0;
    logic [CRW-1:0]  coarse = '0;
    logic            busy, valid;
    logic [SW-1:0]   sum;
    logic [CRW-1:0]  coarse_out;

    int total = 0;
    int bad   = 0;

    always #(CLK_P/2) clk = ~clk;

    avg_tdc_backend #(
        .NUM_CHAINS  (M),
        .NUM_SAMPLES (N),
        .CODE_W      (CW),
        .CLK_BINS    (P),
        .COARSE_W    (CRW)
    ) u_avg_tdc_backend (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_i    (hit),
        .fine_i   (fine),
        .coarse_i (coarse),
        .busy_o   (busy),
        .valid_o  (valid),
        .sum_o    (sum),
        .coarse_o (coarse_out)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int code_of(input int seed, input int c, input int k);
        if (seed == 0) return 0;
        if (seed == 1) return (1 << CW) - 1;
        return (seed * 37 + c * 101 + k * 53 + seed * c * k * 7) % 512;
    endfunction

    function automatic int noise_of(input int seed, input int c, input int j);
        return (seed * 13 + j * 71 + c * 29 + 5) % 512;
    endfunction

    function automatic longint expect_sum(input int seed);
        longint s = 0;
        for (int c = 0; c < M; c++)
            for (int k = 0; k < N; k++)
                s += code_of(seed, c, k) + k * P;
        return s;
    endfunction

    // mode 0 plain, 1 stray hit in first busy cycle, 2 stray hits every busy cycle
    // including the pulse cycle, 3 plain then an idle gap
    task automatic run_hit(input int seed, input int mode);
        string req;
        int    cval;
        @(negedge clk);
        check("R8", "busy before hit", busy, 0);
        check("R6", "valid before hit", valid, 0);
        cval   = (seed * 211 + 7) % 65536;
        hit    = 1'b1;
        coarse = CRW'(cval);
        for (int c = 0; c < M; c++) fine[c*CW +: CW] = CW'(code_of(seed, c, 0));
        for (int j = 1; j < LAT; j++) begin
            @(negedge clk);
            check("R6", "busy during measurement", busy, 1);
            check("R5", "valid early", valid, 0);
            hit    = (mode == 2) || (mode == 1 && j == 1);
            coarse = CRW'(cval + j * 3 + 1);
            for (int c = 0; c < M; c++)
                fine[c*CW +: CW] = (j < N) ? CW'(code_of(seed, c, j)) : CW'(noise_of(seed, c, j));
        end
        @(negedge clk);
        check("R5", "valid pulse", valid, 1);
        check("R6", "busy at pulse", busy, 1);
        req = (seed == 0) ? "R3" : (seed == 1) ? "R10" : (mode != 0) ? "R7" : "R4";
        check(req, "sum", longint'(sum), expect_sum(seed));
        check("R9", "coarse", coarse_out, cval);
        hit = (mode == 2);
        for (int c = 0; c < M; c++) fine[c*CW +: CW] = CW'(noise_of(seed, c, 99));
        if (mode == 3) begin
            @(negedge clk);
            hit = 1'b0;
            check("R6", "busy after pulse", busy, 0);
            check("R5", "single pulse", valid, 0);
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        total++;
        bad++;
        $display("FAIL R5 watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "busy in reset", busy, 0);
        check("R1", "valid in reset", valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "busy after reset", busy, 0);
        check("R1", "valid after reset", valid, 0);
        check("R2", "no start without hit", busy, 0);
        for (int seed = 0; seed < 48; seed++) run_hit(seed, seed % 4);
        @(negedge clk);
        hit = 1'b0;
        check("R6", "busy after last", busy, 0);
        for (int j = 0; j < 6; j++) begin
            @(negedge clk);
            check("R7", "no extra pulse", valid, 0);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule